// File: doc/BRIEF.md
# Trap Arbiter and Redirect Unit

This execute-stage block decides, on every cycle, whether the instruction now in execute raises a synchronous exception or whether a pending interrupt is taken at its boundary. When a trap is taken it raises a one-cycle entry pulse. It also builds the record that the control-register file stores: a cause word, a saved program counter and a trap value. At the same moment it suppresses the side effects of a faulting instruction.

The same block picks the fetch redirect target for the whole stage, in fixed priority: trap vector, return-from-trap address, register-indirect jump target, branch target. Any redirect raises a single flush that clears the decode valid bit, turns execute into a bubble and invalidates the fetch buffer. The interrupt pins are asynchronous, so they pass through a parameterised flop synchronizer before they are arbitrated.

Top module: `trap_arbiter`

## Requirements
- R1: The cause word has bit XLEN-1 = 0 for exceptions. Its low five bits hold the code: 0 fetch-target misaligned, 2 illegal, 3 breakpoint, 4 load misaligned, 6 store misaligned, 11 environment call.
- R2: Misalignment rules. A taken branch or jump target must have bits [1:0] = 0. A word access (mem_size_i = 2'b10) must have address bits [1:0] = 0. A halfword access (2'b01) must have bit 0 = 0. A byte access (2'b00) never faults. A faulting read gives code 4 and a faulting write gives code 6.
- R3: Any exception wins over any interrupt. Among exceptions the order is misalignment, then illegal, then environment call, then breakpoint.
- R4: irq_i and irq_en_i use bit 2 = external, bit 1 = timer, bit 0 = software. An interrupt cause word has bit XLEN-1 = 1. Among interrupts the order is external (code 11), then software (code 3), then timer (code 7).
- R5: An interrupt is taken only when gie_i = 1 and the matching irq_en_i bit is 1. It is not taken when execute holds a return-from-trap instruction or an exception.
- R6: Each irq_i bit passes through SYNC_STAGES flops (default 2) that reset to zero. A pin that rises becomes able to trap after exactly SYNC_STAGES rising edges.
- R7: epc_o is pc_i for exceptions and next_pc_i for interrupts.
- R8: tval_o holds the instruction word for illegal, the faulting target or address for misalignment, and pc_i for breakpoint. It is 0 for environment calls and interrupts.
- R9: The all-zero word never raises illegal. Environment call is exactly 0x00000073, breakpoint exactly 0x00100073, and return-from-trap exactly 0x30200073.
- R10: redirect_pc_o follows the priority trap to mtvec_i (direct mode), then return to mepc_i, then the jalr target, then the branch target. flush_o is 1 whenever any of these applies. mret_o pulses only when no trap is taken.
- R11: An exception clears rf_we_o, mem_we_o and retire_o. An interrupt leaves the instruction in execute to complete.
- R12: With ex_valid_i = 0 there is no trap, no flush and no retire.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ex_valid_i | input | 1 | Execute stage holds a valid instruction |
| insn_i | input | 32 | Instruction word in execute |
| pc_i | input | XLEN | PC of that instruction |
| next_pc_i | input | XLEN | PC of the following instruction |
| illegal_i | input | 1 | Decoder flags the word illegal |
| br_taken_i | input | 1 | Branch or direct jump is taken |
| br_target_i | input | XLEN | Branch or direct jump target |
| jalr_i | input | 1 | Register-indirect jump |
| jalr_target_i | input | XLEN | Register-indirect jump target |
| mem_rd_i | input | 1 | Load |
| mem_wr_i | input | 1 | Store |
| mem_size_i | input | 2 | Access size: 00 byte, 01 half, 10 word |
| mem_addr_i | input | XLEN | Effective address |
| irq_i | input | 3 | Interrupt pins {ext, timer, sw} |
| irq_en_i | input | 3 | Per-source enables, same order |
| gie_i | input | 1 | Global interrupt enable |
| rf_we_i | input | 1 | Register write request |
| mtvec_i | input | XLEN | Trap vector base |
| mepc_i | input | XLEN | Saved return PC |
| trap_o | output | 1 | Trap entry pulse |
| cause_o | output | XLEN | Cause word |
| epc_o | output | XLEN | PC to save |
| tval_o | output | XLEN | Trap value |
| mret_o | output | 1 | Return-from-trap executes |
| flush_o | output | 1 | Flush decode, bubble execute, drop fetch buffer |
| redirect_pc_o | output | XLEN | Fetch redirect target |
| rf_we_o | output | 1 | Qualified register write |
| mem_we_o | output | 1 | Qualified memory write |
| retire_o | output | 1 | Instruction retires |

## Verification
The bench targets overlaps between causes. It drives illegal together with a misaligned word load, an environment call together with a misaligned address, and all three interrupts at once. A wrong priority chain shows up as the wrong cause code. It also feeds the all-zero word with the illegal flag set, byte and halfword accesses on boundaries that are legal for their size, and return-from-trap together with an enabled interrupt. A design that decoded these wrongly would trap when it should not, or would lose the return redirect. The synchronizer latency is checked one edge early and on the exact edge, so a missing or extra flop stage is caught.

// File: rtl/trap_pkg.sv
package trap_pkg;
  localparam int unsigned ILEN = 32;
  localparam int unsigned IRQ_N = 3;
  localparam int unsigned IRQ_SW = 0;
  localparam int unsigned IRQ_TMR = 1;
  localparam int unsigned IRQ_EXT = 2;
  localparam int unsigned CODE_W = 5;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } mem_size_e;

  localparam logic [CODE_W-1:0] EC_IMISAL = 5'd0;
  localparam logic [CODE_W-1:0] EC_ILLEGAL = 5'd2;
  localparam logic [CODE_W-1:0] EC_BREAK = 5'd3;
  localparam logic [CODE_W-1:0] EC_LMISAL = 5'd4;
  localparam logic [CODE_W-1:0] EC_SMISAL = 5'd6;
  localparam logic [CODE_W-1:0] EC_ECALL = 5'd11;
  localparam logic [CODE_W-1:0] IC_SW = 5'd3;
  localparam logic [CODE_W-1:0] IC_TMR = 5'd7;
  localparam logic [CODE_W-1:0] IC_EXT = 5'd11;

  localparam logic [ILEN-1:0] W_ECALL = 32'h0000_0073;
  localparam logic [ILEN-1:0] W_EBREAK = 32'h0010_0073;
  localparam logic [ILEN-1:0] W_MRET = 32'h3020_0073;
endpackage

// File: rtl/trap_irq_sync.sv
module trap_irq_sync #(
  parameter int unsigned N = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  generate
    if (STAGES == 0) begin : g_bypass
      assign q_o = d_i;
    end else begin : g_chain
      logic [N-1:0] st_q [STAGES];
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          for (int i = 0; i < STAGES; i++) st_q[i] <= '0;
        end else begin
          st_q[0] <= d_i;
          for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
      end
      assign q_o = st_q[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/trap_misalign_chk.sv
module trap_misalign_chk
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic            br_v_i,
  input  logic [XLEN-1:0] br_target_i,
  input  logic            jalr_v_i,
  input  logic [XLEN-1:0] jalr_target_i,
  input  logic            rd_v_i,
  input  logic            wr_v_i,
  input  logic [1:0]      size_i,
  input  logic [XLEN-1:0] addr_i,
  output logic            imis_o,
  output logic            lmis_o,
  output logic            smis_o,
  output logic [XLEN-1:0] bad_addr_o
);
  logic [XLEN-1:0] tgt;
  logic            amis;

  assign tgt    = jalr_v_i ? jalr_target_i : br_target_i;
  assign imis_o = (jalr_v_i | br_v_i) & (|tgt[1:0]);
  assign amis   = ((size_i == SZ_WORD) & (|addr_i[1:0])) |
                  ((size_i == SZ_HALF) & addr_i[0]);
  assign lmis_o = rd_v_i & amis;
  assign smis_o = wr_v_i & ~rd_v_i & amis;
  assign bad_addr_o = imis_o ? tgt : addr_i;
endmodule

// File: rtl/trap_cause_sel.sv
module trap_cause_sel
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic             imis_i,
  input  logic             lmis_i,
  input  logic             smis_i,
  input  logic             ill_i,
  input  logic             ecall_i,
  input  logic             ebreak_i,
  input  logic [IRQ_N-1:0] irq_req_i,
  input  logic [ILEN-1:0]  insn_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic [XLEN-1:0]  bad_addr_i,
  output logic             take_o,
  output logic             exc_o,
  output logic [XLEN-1:0]  cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  tval_o
);
  logic              is_irq;
  logic [CODE_W-1:0] code;

  always_comb begin
    take_o = 1'b1;
    is_irq = 1'b0;
    code   = '0;
    tval_o = '0;
    epc_o  = pc_i;
    if (imis_i | lmis_i | smis_i) begin
      code   = imis_i ? EC_IMISAL : (lmis_i ? EC_LMISAL : EC_SMISAL);
      tval_o = bad_addr_i;
    end else if (ill_i) begin
      code   = EC_ILLEGAL;
      tval_o = XLEN'(insn_i);
    end else if (ecall_i) begin
      code = EC_ECALL;
    end else if (ebreak_i) begin
      code   = EC_BREAK;
      tval_o = pc_i;
    end else if (|irq_req_i) begin
      is_irq = 1'b1;
      epc_o  = next_pc_i;
      // non-numeric order: ext > sw > timer
      if (irq_req_i[IRQ_EXT])     code = IC_EXT;
      else if (irq_req_i[IRQ_SW]) code = IC_SW;
      else                        code = IC_TMR;
    end else begin
      take_o = 1'b0;
    end
  end

  assign exc_o   = take_o & ~is_irq;
  assign cause_o = {is_irq, {(XLEN-1-CODE_W){1'b0}}, code};
endmodule

// File: rtl/trap_arbiter.sv
module trap_arbiter
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ex_valid_i,
  input  logic [ILEN-1:0]  insn_i,
  input  logic [XLEN-1:0]  pc_i,
  input  logic [XLEN-1:0]  next_pc_i,
  input  logic             illegal_i,
  input  logic             br_taken_i,
  input  logic [XLEN-1:0]  br_target_i,
  input  logic             jalr_i,
  input  logic [XLEN-1:0]  jalr_target_i,
  input  logic             mem_rd_i,
  input  logic             mem_wr_i,
  input  logic [1:0]       mem_size_i,
  input  logic [XLEN-1:0]  mem_addr_i,
  input  logic [IRQ_N-1:0] irq_i,
  input  logic [IRQ_N-1:0] irq_en_i,
  input  logic             gie_i,
  input  logic             rf_we_i,
  input  logic [XLEN-1:0]  mtvec_i,
  input  logic [XLEN-1:0]  mepc_i,
  output logic             trap_o,
  output logic [XLEN-1:0]  cause_o,
  output logic [XLEN-1:0]  epc_o,
  output logic [XLEN-1:0]  tval_o,
  output logic             mret_o,
  output logic             flush_o,
  output logic [XLEN-1:0]  redirect_pc_o,
  output logic             rf_we_o,
  output logic             mem_we_o,
  output logic             retire_o
);
  logic             br_v, jalr_v, is_mret, is_ecall, is_ebreak, ill_v;
  logic             imis, lmis, smis, exc;
  logic [XLEN-1:0]  bad_addr;
  logic [IRQ_N-1:0] irq_s, irq_req;

  assign br_v      = ex_valid_i & br_taken_i;
  assign jalr_v    = ex_valid_i & jalr_i;
  assign is_mret   = ex_valid_i & (insn_i == W_MRET);
  assign is_ecall  = ex_valid_i & (insn_i == W_ECALL);
  assign is_ebreak = ex_valid_i & (insn_i == W_EBREAK);
  // all-zero word is a NOP hint
  assign ill_v     = ex_valid_i & illegal_i & (|insn_i);

  trap_irq_sync #(.N(IRQ_N), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (irq_i),
    .q_o   (irq_s)
  );

  assign irq_req = irq_s & irq_en_i & {IRQ_N{gie_i & ex_valid_i & ~is_mret}};

  trap_misalign_chk #(.XLEN(XLEN)) u_mis (
    .br_v_i       (br_v),
    .br_target_i  (br_target_i),
    .jalr_v_i     (jalr_v),
    .jalr_target_i(jalr_target_i),
    .rd_v_i       (ex_valid_i & mem_rd_i),
    .wr_v_i       (ex_valid_i & mem_wr_i),
    .size_i       (mem_size_i),
    .addr_i       (mem_addr_i),
    .imis_o       (imis),
    .lmis_o       (lmis),
    .smis_o       (smis),
    .bad_addr_o   (bad_addr)
  );

  trap_cause_sel #(.XLEN(XLEN)) u_sel (
    .imis_i    (imis),
    .lmis_i    (lmis),
    .smis_i    (smis),
    .ill_i     (ill_v),
    .ecall_i   (is_ecall),
    .ebreak_i  (is_ebreak),
    .irq_req_i (irq_req),
    .insn_i    (insn_i),
    .pc_i      (pc_i),
    .next_pc_i (next_pc_i),
    .bad_addr_i(bad_addr),
    .take_o    (trap_o),
    .exc_o     (exc),
    .cause_o   (cause_o),
    .epc_o     (epc_o),
    .tval_o    (tval_o)
  );

  assign mret_o = is_mret & ~trap_o;

  always_comb begin
    flush_o       = 1'b1;
    redirect_pc_o = '0;
    if (trap_o)      redirect_pc_o = {mtvec_i[XLEN-1:2], 2'b00};
    else if (mret_o) redirect_pc_o = mepc_i;
    else if (jalr_v) redirect_pc_o = jalr_target_i;
    else if (br_v)   redirect_pc_o = br_target_i;
    else             flush_o = 1'b0;
  end

  assign rf_we_o  = ex_valid_i & rf_we_i & ~exc;
  assign mem_we_o = ex_valid_i & mem_wr_i & ~exc;
  assign retire_o = ex_valid_i & ~exc;
endmodule

// File: rtl/trap_arbiter_chk.sv
module trap_arbiter_chk
  import trap_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ex_valid_i,
  input logic [ILEN-1:0]  insn_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [XLEN-1:0]  next_pc_i,
  input logic             illegal_i,
  input logic             gie_i,
  input logic             mem_rd_i,
  input logic [XLEN-1:0]  mtvec_i,
  input logic [XLEN-1:0]  mepc_i,
  input logic             trap_o,
  input logic [XLEN-1:0]  cause_o,
  input logic [XLEN-1:0]  epc_o,
  input logic [XLEN-1:0]  tval_o,
  input logic             mret_o,
  input logic             flush_o,
  input logic [XLEN-1:0]  redirect_pc_o,
  input logic             rf_we_o,
  input logic             mem_we_o,
  input logic             retire_o
);
  assert_exc_first_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ex_valid_i && illegal_i && (|insn_i)) |-> (trap_o && !cause_o[XLEN-1]));

  assert_irq_gated_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && cause_o[XLEN-1]) |-> (gie_i && ex_valid_i));

  assert_epc_src_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (epc_o == (cause_o[XLEN-1] ? next_pc_i : pc_i)));

  assert_brk_tval_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && cause_o == XLEN'(EC_BREAK)) |-> (tval_o == pc_i));

  assert_load_code_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && cause_o == XLEN'(EC_LMISAL)) |-> mem_rd_i);

  assert_trap_vec_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trap_o |-> (flush_o && redirect_pc_o[XLEN-1:2] == mtvec_i[XLEN-1:2]));

  assert_mret_ret_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mret_o |-> (!trap_o && flush_o && redirect_pc_o == mepc_i));

  assert_kill_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trap_o && !cause_o[XLEN-1]) |-> (!rf_we_o && !mem_we_o && !retire_o));

  assert_idle_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |-> (!trap_o && !flush_o && !retire_o));
endmodule

bind trap_arbiter trap_arbiter_chk #(.XLEN(XLEN)) u_chk (.*);

// File: tb/trap_arbiter_tb.sv
`timescale 1ns/1ps
module trap_arbiter_tb;
  localparam int unsigned XLEN = 32;
  localparam logic [31:0] PC = 32'h1000, NPC = 32'h1004, VEC = 32'h80, EPC = 32'h2000;
  localparam logic [31:0] ADDI = 32'h0000_0013, ILL = 32'hFFFF_FFFF;
  localparam logic [31:0] EC = 32'h0000_0073, EB = 32'h0010_0073, MR = 32'h3020_0073;
  localparam logic [1:0] B = 2'b00, H = 2'b01, W = 2'b10;

  typedef struct packed {
    logic [31:0] insn; logic ill; logic br; logic jr; logic [31:0] tgt;
    logic rd; logic wr; logic [1:0] sz; logic [31:0] addr;
    logic [2:0] irq; logic [2:0] ien; logic gie;
    logic e_trap; logic [31:0] e_cause; logic [31:0] e_tval; logic e_flush; logic [31:0] e_pc;
  } vec_t;

  // br_target = tgt + 0x100, jalr_target = tgt
  localparam int NV = 25;
  localparam vec_t TBL [NV] = '{
    '{ADDI,0,0,0,0,0,0,W,0,0,0,0, 0,0,0,0,0},                          // plain
    '{32'h0,1,0,0,0,0,0,W,0,0,0,0, 0,0,0,0,0},                         // R9 zero word
    '{ILL,1,0,0,0,0,0,W,0,0,0,0, 1,2,ILL,1,VEC},                       // R1 illegal
    '{EC,0,0,0,0,0,0,W,0,0,0,0, 1,11,0,1,VEC},                         // R9 ecall
    '{EB,0,0,0,0,0,0,W,0,0,0,0, 1,3,PC,1,VEC},                         // R8 ebreak
    '{32'h2003,0,0,0,0,1,0,W,32'h2002,0,0,0, 1,4,32'h2002,1,VEC},      // R2 lw
    '{32'h1023,0,0,0,0,0,1,H,32'h2001,0,0,0, 1,6,32'h2001,1,VEC},      // R2 sh
    '{32'h0023,0,0,0,0,0,1,B,32'h2003,0,0,0, 0,0,0,0,0},               // R2 sb
    '{32'h1003,0,0,0,0,1,0,H,32'h2002,0,0,0, 0,0,0,0,0},               // R2 lh
    '{ADDI,0,1,0,32'h1002,0,0,W,0,0,0,0, 1,0,32'h1102,1,VEC},          // R2 branch
    '{ADDI,0,1,0,32'h1000,0,0,W,0,0,0,0, 0,0,0,1,32'h1100},            // R10 branch
    '{ADDI,0,1,1,32'h3000,0,0,W,0,0,0,0, 0,0,0,1,32'h3000},            // R10 jalr>br
    '{MR,0,0,0,0,0,0,W,0,0,0,0, 0,0,0,1,EPC},                          // R10 mret
    '{ADDI,0,0,0,0,0,0,W,0,3'b100,3'b100,1, 1,32'h8000000B,0,1,VEC},   // R4 ext
    '{ADDI,0,0,0,0,0,0,W,0,3'b111,3'b111,1, 1,32'h8000000B,0,1,VEC},   // R4 all
    '{ADDI,0,0,0,0,0,0,W,0,3'b011,3'b111,1, 1,32'h80000003,0,1,VEC},   // R4 sw>tmr
    '{ADDI,0,0,0,0,0,0,W,0,3'b010,3'b111,1, 1,32'h80000007,0,1,VEC},   // R4 tmr
    '{ADDI,0,0,0,0,0,0,W,0,3'b111,3'b111,0, 0,0,0,0,0},                // R5 gie off
    '{ADDI,0,0,0,0,0,0,W,0,3'b010,3'b101,1, 0,0,0,0,0},                // R5 masked
    '{ILL,1,0,0,0,0,0,W,0,3'b100,3'b100,1, 1,2,ILL,1,VEC},             // R3 exc>irq
    '{ILL,1,0,0,0,1,0,W,32'h2002,0,0,0, 1,4,32'h2002,1,VEC},           // R3 mis>ill
    '{EC,0,0,0,0,1,0,W,32'h2001,0,0,0, 1,4,32'h2001,1,VEC},            // R3 mis>ecall
    '{MR,0,0,0,0,0,0,W,0,3'b100,3'b100,1, 0,0,0,1,EPC},                // R5 mret defers
    '{EC,0,1,0,32'h1000,0,0,W,0,0,0,0, 1,11,0,1,VEC},                  // R10 trap>br
    '{ADDI,0,0,1,32'h3001,0,0,W,0,0,0,0, 1,0,32'h3001,1,VEC}           // R2 jalr
  };

  logic clk_i = 0, rst_ni = 0;
  logic ex_valid_i, illegal_i, br_taken_i, jalr_i, mem_rd_i, mem_wr_i, gie_i, rf_we_i;
  logic [31:0] insn_i, pc_i, next_pc_i, br_target_i, jalr_target_i, mem_addr_i, mtvec_i, mepc_i;
  logic [1:0] mem_size_i;
  logic [2:0] irq_i, irq_en_i;
  logic trap_o, mret_o, flush_o, rf_we_o, mem_we_o, retire_o;
  logic [31:0] cause_o, epc_o, tval_o, redirect_pc_o;
  int checks = 0, fails = 0;

  always #2.5 clk_i = ~clk_i;

  trap_arbiter #(.XLEN(XLEN), .SYNC_STAGES(2)) u_dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic apply(input vec_t v);
    insn_i = v.insn; illegal_i = v.ill; br_taken_i = v.br; jalr_i = v.jr;
    jalr_target_i = v.tgt; br_target_i = v.tgt + 32'h100;
    mem_rd_i = v.rd; mem_wr_i = v.wr; mem_size_i = v.sz; mem_addr_i = v.addr;
    irq_i = v.irq; irq_en_i = v.ien; gie_i = v.gie;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    pc_i = PC; next_pc_i = NPC; mtvec_i = VEC; mepc_i = EPC; rf_we_i = 1; ex_valid_i = 1;
    apply(TBL[0]);
    irq_i = 3'b100; irq_en_i = 3'b100; gie_i = 1;
    repeat (3) @(negedge clk_i);
    chk("R6 no trap in reset", {31'b0, trap_o}, 0);
    rst_ni = 1;
    @(posedge clk_i); @(negedge clk_i);
    chk("R6 one edge too early", {31'b0, trap_o}, 0);
    @(posedge clk_i); @(negedge clk_i);
    chk("R6 trap after two edges", {31'b0, trap_o}, 1);
    chk("R6 cause", cause_o, 32'h8000000B);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      logic exc;
      v = TBL[i];
      exc = v.e_trap & ~v.e_cause[31];
      apply(v);
      @(posedge clk_i); @(posedge clk_i); @(negedge clk_i);
      chk($sformatf("R3/R5/R9 trap v%0d", i), {31'b0, trap_o}, {31'b0, v.e_trap});
      chk($sformatf("R10 flush v%0d", i), {31'b0, flush_o}, {31'b0, v.e_flush});
      chk($sformatf("R11 rf_we v%0d", i), {31'b0, rf_we_o}, {31'b0, ~exc});
      chk($sformatf("R11 retire v%0d", i), {31'b0, retire_o}, {31'b0, ~exc});
      chk($sformatf("R11 mem_we v%0d", i), {31'b0, mem_we_o}, {31'b0, v.wr & ~exc});
      if (v.e_flush) chk($sformatf("R10 target v%0d", i), redirect_pc_o, v.e_pc);
      if (v.e_trap) begin
        chk($sformatf("R1/R2/R4 cause v%0d", i), cause_o, v.e_cause);
        chk($sformatf("R8 tval v%0d", i), tval_o, v.e_tval);
        chk($sformatf("R7 epc v%0d", i), epc_o, v.e_cause[31] ? NPC : PC);
      end
    end

    // R12: invalid execute slot
    apply(TBL[19]);
    ex_valid_i = 0;
    @(posedge clk_i); @(negedge clk_i);
    chk("R12 no trap", {31'b0, trap_o}, 0);
    chk("R12 no flush", {31'b0, flush_o}, 0);
    chk("R12 no retire", {31'b0, retire_o}, 0);
    ex_valid_i = 1;
    @(negedge clk_i);
    chk("R3 exception back on valid", cause_o, 2);

    // R9: near-miss of ECALL word is not ECALL
    apply(TBL[0]);
    insn_i = 32'h0000_00F3;
    @(negedge clk_i);
    chk("R9 near-miss word", {31'b0, trap_o}, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule